// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits inside a synchronous DRAM model and supplies the column address for every beat of a read or write burst. A mode word, captured from the address bus on a mode-set cycle, fixes the burst length, the wrap ordering, a latency value that other logic consumes, and an option that shortens every write to one beat while reads keep the programmed length.

When a read or write command is sampled, the block latches the starting column and the burst shape, then presents one column per clock together with a valid strobe. A done pulse marks the final beat of a fixed-length burst. A full-page burst walks every column of the row and runs until a stop request or a new command ends it. A new command may arrive on any clock; it abandons the current burst and starts over at the new column.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, col_valid, burst_done and cas_lat are 0, col_addr is 0 while col_valid is low, and the mode word is all zeros (one-beat bursts, sequential order).
- R2: A clock with mrs_load high stores mrs_bits; from the next cycle cas_lat equals mrs_bits[6:4]. Bits [2:0] select the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and the unused codes 4, 5 and 6 give 1 beat.
- R3: One cycle after cmd_start is sampled, col_valid is high and col_addr equals the sampled start_col.
- R4: With mrs_bits[3]=0 (sequential) and burst length BL=2^k, beat i carries the upper bits of the start column unchanged and low k bits equal to (start + i) mod BL.
- R5: With mrs_bits[3]=1 (interleave) and burst length 2^k, beat i carries the upper bits of the start column unchanged and low k bits equal to the start's low k bits XOR i.
- R6: burst_done is high exactly during the last beat of a fixed-length burst; col_valid falls only in the cycle after burst_done or a sampled stop.
- R7: A full-page burst steps the column by one each beat, wraps from 1023 to 0, never raises burst_done, and ignores the interleave bit.
- R8: A stop sampled without cmd_start drops col_valid in the next cycle without a done pulse; when cmd_start and stop are sampled together the new burst starts.
- R9: A cmd_start sampled during a burst restarts it: the next beat is the new start column followed by the new burst's sequence.
- R10: With mrs_bits[9]=1, a write command gives a single beat with burst_done, while a read keeps the programmed length; with mrs_bits[9]=0 a write bursts like a read.
- R11: A mode load during a burst leaves the length and order of that burst unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_load | input | 1 | Mode-set cycle: capture mrs_bits |
| mrs_bits | input | 10 | Mode word taken from the address bus |
| cmd_start | input | 1 | Read or write command with a start column |
| cmd_write | input | 1 | 1 for a write command, 0 for a read |
| start_col | input | 10 | Starting column of the burst |
| stop | input | 1 | Terminate the running burst |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | col_addr holds a beat of a burst |
| burst_done | output | 1 | Current beat is the last of a fixed-length burst |
| cas_lat | output | 3 | Latency field of the stored mode word |

## Verification
A corrupted beat index or latched base shows at the ports on the very next beat as a wrong col_addr, and a wrong latched mask shows either as upper column bits that move within a burst or as burst_done appearing one or more beats early or late. A stuck active flag shows as col_valid staying high after done or stop, visible one cycle after the ending event. A bad mode field is exposed by the first burst after the mode-set cycle, and cas_lat exposes the latency field one cycle after the load.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int COL_W   = 10;
  localparam int MODE_W  = 10;
  localparam int LEN_LSB = 0;
  localparam int ORD_BIT = 3;
  localparam int CL_LSB  = 4;
  localparam int WS_BIT  = 9;

  typedef logic [COL_W-1:0] col_t;
  typedef enum logic {ORDER_SEQ = 1'b0, ORDER_ILV = 1'b1} order_e;

  localparam logic [2:0] LEN_PAGE = 3'd7;

  // Mask of the column bits that wrap inside one burst.
  function automatic col_t wrap_mask(input logic [2:0] code);
    case (code)
      3'd1:    return col_t'(1);
      3'd2:    return col_t'(3);
      3'd3:    return col_t'(7);
      LEN_PAGE: return '1;
      default: return '0;
    endcase
  endfunction

  // Column of beat idx for a burst that began at base.
  function automatic col_t beat_col(input col_t base, input col_t idx,
                                    input col_t mask, input order_e ord);
    col_t low;
    if (ord == ORDER_ILV) low = base ^ idx;
    else                  low = base + idx;
    return (base & ~mask) | (low & mask);
  endfunction
endpackage

// File: rtl/colgen_modereg.sv
module colgen_modereg
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] bits,
  output logic [2:0]        len_code,
  output order_e            order,
  output logic [2:0]        cas_lat,
  output logic              wr_single
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= bits;
  end

  assign len_code  = mode_q[LEN_LSB +: 3];
  assign order     = order_e'(mode_q[ORD_BIT]);
  assign cas_lat   = mode_q[CL_LSB +: 3];
  assign wr_single = mode_q[WS_BIT];
endmodule

// File: rtl/colgen_track.sv
module colgen_track
  import colgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       write,
  input  logic       stop,
  input  col_t       start_col,
  input  logic [2:0] len_code,
  input  order_e     order,
  input  logic       wr_single,
  output col_t       col_addr,
  output logic       valid,
  output logic       last_beat,
  output col_t       cur_mask,
  output logic       cur_page
);
  logic       active_q, page_q;
  col_t       base_q, idx_q, mask_q;
  order_e     ord_q;

  logic [2:0] eff_code;
  logic       ld_page;
  order_e     ld_ord;

  always_comb begin
    eff_code = (write && wr_single) ? 3'd0 : len_code;
    ld_page  = (eff_code == LEN_PAGE);
    ld_ord   = ld_page ? ORDER_SEQ : order;
  end

  assign last_beat = active_q && !page_q && (idx_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      page_q   <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      ord_q    <= ORDER_SEQ;
    end else if (start) begin
      active_q <= 1'b1;
      page_q   <= ld_page;
      base_q   <= start_col;
      idx_q    <= '0;
      mask_q   <= wrap_mask(eff_code);
      ord_q    <= ld_ord;
    end else if (active_q) begin
      if (stop || last_beat) active_q <= 1'b0;
      else                   idx_q    <= idx_q + col_t'(1);
    end
  end

  assign valid    = active_q;
  assign col_addr = active_q ? beat_col(base_q, idx_q, mask_q, ord_q) : '0;
  assign cur_mask = mask_q;
  assign cur_page = page_q && active_q;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_load,
  input  logic [MODE_W-1:0] mrs_bits,
  input  logic              cmd_start,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              stop,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_valid,
  output logic              burst_done,
  output logic [2:0]        cas_lat
);
  logic [2:0] len_code;
  order_e     order;
  logic       wr_single;
  col_t       burst_mask;
  logic       burst_page;

  colgen_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .load(mrs_load), .bits(mrs_bits),
    .len_code(len_code), .order(order), .cas_lat(cas_lat), .wr_single(wr_single)
  );

  colgen_track u_track (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .write(cmd_write), .stop(stop),
    .start_col(start_col), .len_code(len_code), .order(order), .wr_single(wr_single),
    .col_addr(col_addr), .valid(col_valid), .last_beat(burst_done),
    .cur_mask(burst_mask), .cur_page(burst_page)
  );
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker
  import colgen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mrs_load,
  input logic [MODE_W-1:0] mrs_bits,
  input logic              cmd_start,
  input logic              cmd_write,
  input logic [COL_W-1:0]  start_col,
  input logic              stop,
  input logic [COL_W-1:0]  col_addr,
  input logic              col_valid,
  input logic              burst_done,
  input logic [2:0]        cas_lat,
  input logic              wr_single,
  input col_t              burst_mask,
  input logic              burst_page
);
  assert_cas_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_load |=> cas_lat == $past(mrs_bits[6:4]));

  assert_start_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> col_valid && col_addr == $past(start_col));

  assert_upper_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !cmd_start && !stop && !burst_done) |=>
      col_valid && ((col_addr & ~burst_mask) == ($past(col_addr) & ~burst_mask)));

  assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> col_valid);

  assert_end_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_valid) |-> $past(burst_done || stop));

  assert_page_nodone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_page |-> !burst_done);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !cmd_start) |=> !col_valid);

  assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_write && wr_single && !mrs_load) |=> burst_done);
endmodule

bind sdram_burst_colgen colgen_checker i_colgen_checker (
  .clk(clk), .rst_n(rst_n), .mrs_load(mrs_load), .mrs_bits(mrs_bits),
  .cmd_start(cmd_start), .cmd_write(cmd_write), .start_col(start_col), .stop(stop),
  .col_addr(col_addr), .col_valid(col_valid), .burst_done(burst_done),
  .cas_lat(cas_lat), .wr_single(wr_single), .burst_mask(burst_mask),
  .burst_page(burst_page)
);

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_load = 1'b0;
  logic [9:0] mrs_bits = '0;
  logic       cmd_start = 1'b0;
  logic       cmd_write = 1'b0;
  logic [9:0] start_col = '0;
  logic       stop = 1'b0;
  logic [9:0] col_addr;
  logic       col_valid;
  logic       burst_done;
  logic [2:0] cas_lat;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mrs_load(mrs_load), .mrs_bits(mrs_bits),
    .cmd_start(cmd_start), .cmd_write(cmd_write), .start_col(start_col), .stop(stop),
    .col_addr(col_addr), .col_valid(col_valid), .burst_done(burst_done), .cas_lat(cas_lat)
  );

  // {mode word, write, start column, beats expected}
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {10'h032, 1'b0, 10'd165,  11'd4},  // R4 BL4 seq
    {10'h023, 1'b0, 10'd1022, 11'd8},  // R4 BL8 seq, upper bits held
    {10'h00B, 1'b0, 10'd5,    11'd8},  // R5 BL8 interleave
    {10'h021, 1'b0, 10'd7,    11'd2},  // R4 BL2
    {10'h030, 1'b0, 10'd341,  11'd1},  // R2 BL1
    {10'h02A, 1'b0, 10'd514,  11'd4},  // R5 BL4 interleave
    {10'h203, 1'b1, 10'd77,   11'd1},  // R10 single write
    {10'h203, 1'b0, 10'd3,    11'd8},  // R10 read keeps length
    {10'h003, 1'b1, 10'd12,   11'd8},  // R10 write bursts when option off
    {10'h045, 1'b0, 10'd9,    11'd1}   // R2 unused length code
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_mode(input logic [9:0] m);
    mrs_bits = m; mrs_load = 1'b1;
    tick();
    mrs_load = 1'b0;
  endtask

  task automatic go(input logic [9:0] col, input logic wr);
    start_col = col; cmd_write = wr; cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic beat(input string req, input int addr, input bit last);
    chk(req, "col_valid", int'(col_valid), 1);
    chk(req, "col_addr", int'(col_addr), addr);
    chk(req, "burst_done", int'(burst_done), int'(last));
  endtask

  task automatic idle(input string req);
    chk(req, "col_valid low", int'(col_valid), 0);
    chk(req, "burst_done low", int'(burst_done), 0);
  endtask

  // Independent model: offset within the aligned block, then wrap by modulo.
  function automatic int model_addr(input int mode, input bit wr, input int st, input int i);
    int code, bl, off;
    code = mode % 8;
    bl = (code >= 1 && code <= 3) ? (1 << code) : 1;
    if (wr && mode >= 512) bl = 1;
    off = st % bl;
    if ((mode / 8) % 2 == 1) return st - off + (off ^ i);
    return st - off + ((off + i) % bl);
  endfunction

  initial begin
    repeat (3) tick();
    // R1 reset state
    idle("R1");
    chk("R1", "col_addr idle", int'(col_addr), 0);
    chk("R1", "cas_lat", int'(cas_lat), 0);
    rst_n = 1'b1;
    tick();
    idle("R1");
    // R1 default mode: one-beat sequential burst
    go(10'd18, 1'b0);
    beat("R1", 18, 1'b1);
    tick();
    idle("R1");

    for (int v = 0; v < NVEC; v++) begin
      int mode, st, n;
      bit wr;
      mode = int'(VEC[v][31:22]);
      wr   = VEC[v][21];
      st   = int'(VEC[v][20:11]);
      n    = int'(VEC[v][10:0]);
      load_mode(VEC[v][31:22]);
      chk("R2", "cas_lat", int'(cas_lat), (mode / 16) % 8);
      go(VEC[v][20:11], wr);
      chk("R3", "first col", int'(col_addr), st);
      for (int i = 0; i < n; i++) begin
        beat((mode / 8) % 2 == 1 ? "R5" : "R4", model_addr(mode, wr, st, i), i == n - 1);
        tick();
      end
      idle("R6");
    end

    // R7 full page with wrap past the last column
    load_mode(10'h027);
    go(10'd1022, 1'b0);
    for (int i = 0; i < 5; i++) begin
      beat("R7", (1022 + i) % 1024, 1'b0);
      if (i < 4) tick();
    end
    stop = 1'b1; tick(); stop = 1'b0;
    idle("R8");
    // R7 interleave bit has no effect on full page
    load_mode(10'h00F);
    go(10'd1, 1'b0);
    beat("R7", 1, 1'b0); tick();
    beat("R7", 2, 1'b0); tick();
    beat("R7", 3, 1'b0);
    stop = 1'b1; tick(); stop = 1'b0;
    idle("R7");

    // R8 stop in the middle of an eight-beat burst
    load_mode(10'h003);
    go(10'd0, 1'b0);
    beat("R8", 0, 1'b0); tick();
    beat("R8", 1, 1'b0);
    stop = 1'b1; tick(); stop = 1'b0;
    idle("R8");
    // R8 start and stop together: start wins
    start_col = 10'd40; cmd_start = 1'b1; stop = 1'b1;
    tick();
    cmd_start = 1'b0; stop = 1'b0;
    beat("R8", 40, 1'b0);
    // R9 restart while the burst runs
    go(10'd100, 1'b0);
    beat("R9", 100, 1'b0); tick();
    beat("R9", 101, 1'b0); tick();
    beat("R9", 102, 1'b0);
    stop = 1'b1; tick(); stop = 1'b0;
    idle("R9");

    // R11 mode change inside a burst
    load_mode(10'h002);
    go(10'd8, 1'b0);
    beat("R11", 8, 1'b0);
    load_mode(10'h00B);
    beat("R11", 9, 1'b0); tick();
    beat("R11", 10, 1'b0); tick();
    beat("R11", 11, 1'b1); tick();
    idle("R11");
    chk("R11", "cas_lat after load", int'(cas_lat), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule